// File: doc/BRIEF.md
# Single-Level Page Table Translator

The translator turns a 15-bit virtual address into a 13-bit physical address by reading one entry from a page table in physical memory. Pages are 1 KB, so the ten low address bits pass through unchanged. The five bits above them select one of 32 table entries. Each entry is a 16-bit word at byte address `table base + 2 * page index`, taken modulo 8192. The entry supplies a valid flag, a rights field and a 3-bit frame number. A request also says whether it is a load, a store or an instruction fetch, and the translator refuses any access the entry's rights do not grant.

A control state machine handles one request at a time. In `ST_IDLE`, `req_ready` is high, and a request accepted there moves the machine to `ST_READ`. In `ST_READ`, the entry read is issued on the memory port, and the machine always moves on to `ST_WAIT`. In `ST_WAIT`, the returned word is judged and registered, and the machine always moves on to `ST_RESP`. In `ST_RESP`, the one-cycle response is presented, and the machine returns to `ST_IDLE`. A response therefore appears exactly three cycles after its request is accepted.

The table base register is written through a separate port. A write while idle takes effect at once. A write made while a lookup is in flight is parked and takes effect only after that lookup's response. Software can therefore switch tables without corrupting a lookup that is already running.

Top module: `pgx_xlate`

## Requirements
- R1: For a valid entry that permits the access, `rsp_pa` equals the entry's frame number (entry bits 2:0) placed above the ten unchanged offset bits of the virtual address.
- R2: Exactly one cycle after a request is accepted, `mem_rd_en` is high for one cycle. `mem_rd_addr` is then the base register plus twice the virtual page number (address bits 14:10), modulo 8192. The entry word is expected on `mem_rd_data` in the following cycle.
- R3: If entry bit 15 is 0, the response has `rsp_page_fault` = 1, `rsp_prot_fault` = 0 and `rsp_pa` = 0, whatever the rights field holds.
- R4: Request kinds are encoded as 00 load, 01 store, 10 fetch and 11 reserved. Entry rights (bits 14:13) are encoded as 00 read-only, 01 read/write, 10 execute-only and 11 no access. Loads are allowed under 00 or 01, stores only under 01 and fetches only under 10. Every other pairing on a valid entry gives `rsp_prot_fault` = 1, `rsp_page_fault` = 0 and `rsp_pa` = 0.
- R5: `rsp_valid` is high for exactly one cycle, three cycles after acceptance. At most one fault flag is set in that cycle.
- R6: `req_ready` is high only while no lookup is in flight. A request held valid during a lookup is not accepted until the response cycle has passed.
- R7: A base write while idle applies at the next edge. This includes the case where a request is accepted in the same cycle, and that request uses the new base.
- R8: A base write made during a lookup does not change that lookup's table address. It takes effect after the response cycle. If several writes occur during one lookup, the last one wins.
- R9: After reset, the base is 0, `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator can accept a request |
| req_va | input | 15 | Virtual address |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| mem_rd_en | output | 1 | Table entry read strobe |
| mem_rd_addr | output | 13 | Byte address of the table entry |
| mem_rd_data | input | 16 | Entry word, one cycle after the strobe |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | 13 | New table base |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 13 | Physical address, 0 on a fault |
| rsp_page_fault | output | 1 | Entry was not valid |
| rsp_prot_fault | output | 1 | Access kind not allowed by the entry |

## Verification
The hardest case to reach from the ports is a base write landing in the middle of a lookup. This includes two writes inside one lookup and a write in the same cycle as an acceptance. The stimulus counts falling edges from the acceptance cycle so that writes fall in the read, wait and response cycles on purpose. It then issues a fresh request, whose table address shows which base value won. The entry contents come from an address hash whose seed changes between sweeps. A full sweep of every page under every access kind therefore meets all rights codes with both settings of the valid flag.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        RT_RDONLY = 2'b00,
        RT_RDWR   = 2'b01,
        RT_EXEC   = 2'b10,
        RT_NONE   = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_RESP
    } walk_state_e;

    // Permission matrix between access kind and entry rights.
    function automatic logic rights_allow(acc_kind_e kind, rights_e rt);
        logic ok;
        unique case (kind)
            ACC_LOAD:  ok = (rt == RT_RDONLY) || (rt == RT_RDWR);
            ACC_STORE: ok = (rt == RT_RDWR);
            ACC_FETCH: ok = (rt == RT_EXEC);
            ACC_NONE:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic take_req,
    output logic issue_rd,
    output logic latch_pte,
    output logic rsp_out,
    output logic busy
);

    walk_state_e state_q;
    walk_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_READ;
            ST_READ: state_d = ST_WAIT;
            ST_WAIT: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        issue_rd  = 1'b0;
        latch_pte = 1'b0;
        rsp_out   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_READ: issue_rd  = 1'b1;
            ST_WAIT: latch_pte = 1'b1;
            ST_RESP: rsp_out   = 1'b1;
        endcase
    end

    assign take_req = req_valid && req_ready;
    assign busy     = (state_q != ST_IDLE);

    a_r2_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |=> issue_rd);

    a_r5_resp_follows_judge: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pte |=> rsp_out);

    a_r5_resp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_out |=> !rsp_out);

    a_r6_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

endmodule

// File: rtl/pgx_base.sv
module pgx_base #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         busy,
    input  logic         release_i,
    output logic [W-1:0] base_q
);

    logic         pend_q;
    logic [W-1:0] pend_data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else if (!busy) begin
            if (wr_en) base_q <= wr_data;
        end else if (release_i) begin
            pend_q <= 1'b0;
            if (wr_en) begin
                base_q <= wr_data;
            end else if (pend_q) begin
                base_q <= pend_data_q;
            end
        end else if (wr_en) begin
            pend_q      <= 1'b1;
            pend_data_q <= wr_data;
        end
    end

    a_r8_base_held_in_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !release_i) |=> $stable(base_q));

    a_r8_no_parked_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pend_q);

    a_r7_idle_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> (base_q == $past(wr_data)));

endmodule

// File: rtl/pgx_judge.sv
module pgx_judge
    import pgx_pkg::*;
#(
    parameter int PTE_W = 16,
    parameter int PPN_W = 3
) (
    input  logic [PTE_W-1:0] pte,
    input  acc_kind_e        kind,
    output logic             pg_fault,
    output logic             pr_fault,
    output logic [PPN_W-1:0] ppn
);

    localparam int V_BIT = PTE_W - 1;
    localparam int RT_HI = PTE_W - 2;
    localparam int RT_LO = PTE_W - 3;

    rights_e rt;

    assign rt       = rights_e'(pte[RT_HI:RT_LO]);
    assign pg_fault = !pte[V_BIT];
    assign pr_fault = pte[V_BIT] && !rights_allow(kind, rt);
    assign ppn      = pte[PPN_W-1:0];

    // Bits between the rights field and the frame number carry no meaning.
    if (RT_LO > PPN_W) begin : g_spare
        logic spare_unused;
        assign spare_unused = ^pte[RT_LO-1:PPN_W];
    end

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter  int OFS_W  = 10,
    parameter  int VPN_W  = 5,
    parameter  int PPN_W  = 3,
    parameter  int PTE_W  = 16,
    localparam int VA_W   = OFS_W + VPN_W,
    localparam int PA_W   = OFS_W + PPN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_kind,
    output logic             mem_rd_en,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             base_wr_en,
    input  logic [PA_W-1:0]  base_wr_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault
);

    localparam int PTE_BYTES = PTE_W / 8;
    localparam int PTE_SH    = $clog2(PTE_BYTES);

    logic             take_req;
    logic             latch_pte;
    logic             rsp_out;
    logic             busy;
    logic [PA_W-1:0]  base_q;
    logic [VA_W-1:0]  va_q;
    acc_kind_e        kind_q;
    logic             pg_fault;
    logic             pr_fault;
    logic [PPN_W-1:0] ppn;
    logic             pf_q;
    logic             pr_q;
    logic [PA_W-1:0]  pa_q;

    pgx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .take_req  (take_req),
        .issue_rd  (mem_rd_en),
        .latch_pte (latch_pte),
        .rsp_out   (rsp_out),
        .busy      (busy)
    );

    pgx_base #(.W(PA_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (base_wr_en),
        .wr_data   (base_wr_data),
        .busy      (busy),
        .release_i (rsp_out),
        .base_q    (base_q)
    );

    pgx_judge #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_judge (
        .pte      (mem_rd_data),
        .kind     (kind_q),
        .pg_fault (pg_fault),
        .pr_fault (pr_fault),
        .ppn      (ppn)
    );

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            kind_q <= ACC_LOAD;
        end else if (take_req) begin
            va_q   <= req_va;
            kind_q <= acc_kind_e'(req_kind);
        end
    end

    // Entry address: base plus page index scaled by entry size, wrapping
    assign mem_rd_addr = base_q + (PA_W'(va_q[VA_W-1:OFS_W]) << PTE_SH);

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            pr_q <= 1'b0;
            pa_q <= '0;
        end else if (latch_pte) begin
            pf_q <= pg_fault;
            pr_q <= pr_fault;
            pa_q <= (pg_fault || pr_fault) ? '0 : {ppn, va_q[OFS_W-1:0]};
        end
    end

    assign rsp_valid      = rsp_out;
    assign rsp_pa         = pa_q;
    assign rsp_page_fault = rsp_out && pf_q;
    assign rsp_prot_fault = rsp_out && pr_q;

    a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));

    a_r3_page_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_page_fault) |-> (rsp_pa == '0));

    a_r4_prot_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_prot_fault) |-> (rsp_pa == '0));

    a_r1_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault)
            |-> (rsp_pa[OFS_W-1:0] == va_q[OFS_W-1:0]));

    a_r2_addr_held_for_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> $stable(mem_rd_addr));

endmodule

// File: tb/pgx_xlate_test.sv
`timescale 1ns/1ps
module pgx_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_rd_en;
    logic [12:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        base_wr_en = 1'b0;
    logic [12:0] base_wr_data = '0;
    logic        rsp_valid;
    logic [12:0] rsp_pa;
    logic        rsp_page_fault;
    logic        rsp_prot_fault;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int salt = 0;

    always #2.5 clk = ~clk;

    pgx_xlate uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_va         (req_va),
        .req_kind       (req_kind),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_data    (mem_rd_data),
        .base_wr_en     (base_wr_en),
        .base_wr_data   (base_wr_data),
        .rsp_valid      (rsp_valid),
        .rsp_pa         (rsp_pa),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault)
    );

    // Table contents: a hash of the byte address and a per-sweep seed
    function automatic logic [15:0] pte_word(input int a, input int s);
        logic [31:0] h;
        h = (32'(a) * 32'h9E3779B1) ^ (32'(s) * 32'h85EBCA6B);
        h = h ^ (h >> 15);
        h = h * 32'h2C1B3C6D;
        return h[31:16];
    endfunction

    // Memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= pte_word(int'(mem_rd_addr), salt);
    end

    // Reference model
    int          m_phase = 0;
    int          m_base = 0;
    bit          m_pend = 0;
    int          m_pend_val = 0;
    int          m_va = 0;
    int          m_kind = 0;
    int          m_addr = 0;
    int          m_pa = 0;
    bit          m_pf = 0;
    bit          m_pr = 0;
    bit          m_live = 0;

    always @(posedge clk) begin
        m_live = 1;
        if (!rst_n) begin
            m_phase = 0; m_base = 0; m_pend = 0; m_pend_val = 0;
            m_pa = 0; m_pf = 0; m_pr = 0;
        end else begin
            case (m_phase)
                0: begin
                    if (base_wr_en) m_base = int'(base_wr_data);
                    if (req_valid) begin
                        m_va   = int'(req_va);
                        m_kind = int'(req_kind);
                        m_addr = (m_base + 2 * (m_va / 1024)) % 8192;
                        m_phase = 1;
                    end
                end
                1, 2: begin
                    if (base_wr_en) begin m_pend = 1; m_pend_val = int'(base_wr_data); end
                    if (m_phase == 2) begin
                        logic [15:0] w;
                        bit ok;
                        w = pte_word(m_addr, salt);
                        case (m_kind)
                            0: ok = (w[14:13] == 2'b00) || (w[14:13] == 2'b01);
                            1: ok = (w[14:13] == 2'b01);
                            2: ok = (w[14:13] == 2'b10);
                            default: ok = 0;
                        endcase
                        m_pf = !w[15];
                        m_pr = w[15] && !ok;
                        m_pa = (m_pf || m_pr) ? 0 : (int'(w[2:0]) * 1024 + (m_va % 1024));
                    end
                    m_phase = m_phase + 1;
                end
                default: begin
                    if (base_wr_en) m_base = int'(base_wr_data);
                    else if (m_pend) m_base = m_pend_val;
                    m_pend = 0;
                    m_phase = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Comparison every clock, away from the active edge
    always @(negedge clk) begin
        if (m_live) begin
            if (!rst_n) begin
                chk("R9 ready in reset", int'(req_ready), 1);
                chk("R9 rsp_valid in reset", int'(rsp_valid), 0);
                chk("R9 mem_rd_en in reset", int'(mem_rd_en), 0);
            end else begin
                chk("R6 req_ready", int'(req_ready), (m_phase == 0) ? 1 : 0);
                chk("R2 mem_rd_en", int'(mem_rd_en), (m_phase == 1) ? 1 : 0);
                if (m_phase == 1)
                    chk("R2,R7,R8,R9 table address", int'(mem_rd_addr), m_addr);
                chk("R5 rsp_valid", int'(rsp_valid), (m_phase == 3) ? 1 : 0);
                if (m_phase == 3) begin
                    chk("R1 rsp_pa", int'(rsp_pa), m_pa);
                    chk("R3 rsp_page_fault", int'(rsp_page_fault), int'(m_pf));
                    chk("R4 rsp_prot_fault", int'(rsp_prot_fault), int'(m_pr));
                end
            end
        end
    end

    task automatic send(input int va, input int k);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_va    = 15'(va);
        req_kind  = 2'(k);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_base(input int b);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = 13'(b);
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    task automatic sweep();
        for (int vpn = 0; vpn < 32; vpn++) begin
            for (int k = 0; k < 4; k++) begin
                send(vpn * 1024 + ((vpn * 37 + k * 101 + salt * 13) % 1024), k);
            end
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 R4: full sweep from base 0 left by reset (R9)
        salt = 0;
        sweep();

        // R7: idle writes, including a base near the top that wraps (R2)
        salt = 1;
        wr_base(8190);
        sweep();
        salt = 2;
        wr_base(4097);
        sweep();

        // R7: write in the same cycle as an accepted request
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 13'd300;
        req_valid = 1'b1; req_va = 15'(5 * 1024 + 77); req_kind = 2'd0;
        @(negedge clk);
        base_wr_en = 1'b0; req_valid = 1'b0;
        send(9 * 1024 + 3, 1);

        // R8: one write during the read cycle, then a follow-up lookup
        send(2 * 1024 + 10, 0);
        base_wr_en = 1'b1; base_wr_data = 13'd1000;
        @(negedge clk);
        base_wr_en = 1'b0;
        send(31 * 1024 + 1023, 2);

        // R8: writes in the read and response cycles, last one wins
        send(7 * 1024 + 500, 1);
        base_wr_en = 1'b1; base_wr_data = 13'd2000;
        @(negedge clk);
        base_wr_en = 1'b0;
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 13'd64;
        @(negedge clk);
        base_wr_en = 1'b0;
        send(1 * 1024 + 1, 0);

        // R8: single write during the wait cycle
        send(3 * 1024, 2);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 13'd8191;
        @(negedge clk);
        base_wr_en = 1'b0;
        send(31 * 1024, 0);

        // R6: request held valid through lookups with a changing address
        salt = 3;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_va    = 15'((i * 1531) % 32768);
            req_kind  = 2'(i % 4);
        end
        @(negedge clk);
        req_valid = 1'b0;

        repeat (8) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule